// File: doc/BRIEF.md
# Memory Address and Stack Pointer Unit

This unit sits beside the register file of a word-addressed 32-bit processor and turns one decoded memory instruction per cycle into a memory request. From the instruction word and the three register values read for it, the unit forms a word address. It then drives a read or write strobe with store data. It also produces the register writes that the instruction implies: the loaded word for a load or pop, and the new pointer value for a push or pop.

Three addressing modes are supported. An absolute address comes from a 22-bit field and is zero-extended. A displacement address is a 17-bit sign-extended field added to a base register. An index address is the sum of two registers. Any general register can serve as a stack pointer. Push advances the pointer by one and stores at the advanced value. Pop reads at the current pointer and then steps it back by one. All address arithmetic wraps modulo 2^32.

The request is registered and appears one cycle after issue. The memory returns read data one cycle after the read strobe, and in that cycle the unit presents the data on its load write-back port. A new instruction may be issued in every cycle.

Top module: `lsu_addr_unit`

## Requirements
- R1: While reset is low and after it is released with nothing issued, the strobes `mem_rd_en` and `mem_wr_en` and the write enables `ptr_wr_en` and `ld_wr_en` are all 0.
- R2: Primary opcode 1 (bits 31:27) is an absolute load and opcode 3 is an absolute store. The address is bits 21:0 zero-extended, and the store data is the value of the register in bits 26:22 (`opnd_a`).
- R3: Primary opcode 2 is a displacement load and opcode 4 is a displacement store. The address is `opnd_b` (register in bits 21:17) plus bits 16:0 sign-extended, wrapping modulo 2^32, and the store data is `opnd_a`.
- R4: Primary opcode 31 with extended opcode 17 (bits 11:0) is an index load, and with 18 an index store. The address is `opnd_b + opnd_c` modulo 2^32, and the store data is `opnd_a`.
- R5: A load's request appears in the cycle after issue. In the following cycle, `ld_wr_en` is 1, `ld_wr_idx` holds bits 26:22, and `ld_wr_data` equals `mem_rdata`.
- R6: A push (extended opcode 21), with the pointer in bits 26:22 and the data register in bits 21:17, writes `opnd_b` to address `opnd_a + 1`. In the same cycle the pointer register is written with `opnd_a + 1`. The push makes no load write-back.
- R7: A pop (extended opcode 22) reads at address `opnd_a`. In the same cycle it writes the pointer register with `opnd_a - 1`, and one cycle later it writes the loaded word to the register in bits 21:17.
- R8: A pop whose two register fields are equal makes no pointer write, so that register ends up holding the loaded word.
- R9: Any other opcode, any other extended opcode, and any cycle with `issue_valid` low produce no strobe and no register write.
- R10: At most one of `mem_rd_en` and `mem_wr_en` is high in any cycle.
- R11: Instructions issued in consecutive cycles each produce their own request in consecutive cycles. A load's write-back overlaps the next instruction's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of register named in bits 26:22 |
| opnd_b | input | 32 | Value of register named in bits 21:17 |
| opnd_c | input | 32 | Value of register named in bits 16:12 |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read strobe |
| ptr_wr_en | output | 1 | Pointer register write enable |
| ptr_wr_idx | output | 5 | Pointer register index |
| ptr_wr_data | output | 32 | New pointer value |
| ld_wr_en | output | 1 | Loaded-data register write enable |
| ld_wr_idx | output | 5 | Destination register index |
| ld_wr_data | output | 32 | Loaded word |

## Verification
The bench targets the address corners: an all-ones absolute field, which a sign-extending design would turn negative; a displacement of -1 on a zero base and an index sum past 2^32, which would break if wrapping or sign extension were wrong; and push and pop at the pointer's wrap points. It checks that a push stores at the advanced pointer rather than the old one. It also issues a pop whose destination equals its pointer, where a design that still wrote the pointer would leave a decremented pointer instead of the loaded word. Undefined extended opcodes, non-memory primary opcodes and idle issue slots must stay silent. A back-to-back sequence shows whether a load's write-back is lost or misattributed when the next request overlaps it.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_LOAD,
      K_STORE,
      K_PUSH,
      K_POP
   } acc_kind_e;

   typedef enum logic [1:0] {
      M_ABS,
      M_DISP,
      M_INDEX,
      M_STACK
   } amode_e;

   typedef struct packed {
      acc_kind_e kind;
      amode_e    mode;
   } lsu_ctl_t;

   function automatic logic kind_reads(acc_kind_e k);
      return (k == K_LOAD) || (k == K_POP);
   endfunction

   function automatic logic kind_writes(acc_kind_e k);
      return (k == K_STORE) || (k == K_PUSH);
   endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int OPC_W      = 5,
   parameter int IDX_W      = 5,
   parameter int XOP_W      = 12,
   parameter int OP_LD_ABS  = 1,
   parameter int OP_LD_DSP  = 2,
   parameter int OP_ST_ABS  = 3,
   parameter int OP_ST_DSP  = 4,
   parameter int OP_EXT     = 31,
   parameter int XOP_LD_IDX = 17,
   parameter int XOP_ST_IDX = 18,
   parameter int XOP_PUSH   = 21,
   parameter int XOP_POP    = 22
) (
   input  logic [XLEN-1:0]  instr,
   output lsu_ctl_t         ctl,
   output logic [IDX_W-1:0] fld1,
   output logic [IDX_W-1:0] fld2,
   output logic [XLEN-1:0]  abs_addr,
   output logic [XLEN-1:0]  disp_val
);

   localparam int OPC_LSB = XLEN - OPC_W;
   localparam int F1_LSB  = OPC_LSB - IDX_W;
   localparam int F2_LSB  = F1_LSB - IDX_W;
   localparam int F3_LSB  = F2_LSB - IDX_W;
   localparam int ABS_W   = F1_LSB;
   localparam int DISP_W  = F2_LSB;

   generate
      if (F3_LSB < XOP_W) begin : g_bad_format
         $error("lsu_decode: extended opcode field overlaps third register field");
      end
      if (OPC_W < 1 || IDX_W < 1) begin : g_bad_width
         $error("lsu_decode: field widths must be positive");
      end
   endgenerate

   logic [OPC_W-1:0] opc;
   logic [XOP_W-1:0] xop;

   assign opc      = instr[XLEN-1:OPC_LSB];
   assign xop      = instr[XOP_W-1:0];
   assign fld1     = instr[OPC_LSB-1:F1_LSB];
   assign fld2     = instr[F1_LSB-1:F2_LSB];
   assign abs_addr = {{(XLEN-ABS_W){1'b0}}, instr[ABS_W-1:0]};
   assign disp_val = {{(XLEN-DISP_W){instr[DISP_W-1]}}, instr[DISP_W-1:0]};

   always_comb begin
      ctl = '{kind: K_NONE, mode: M_ABS};
      if (opc == OPC_W'(OP_LD_ABS)) begin
         ctl = '{kind: K_LOAD, mode: M_ABS};
      end else if (opc == OPC_W'(OP_ST_ABS)) begin
         ctl = '{kind: K_STORE, mode: M_ABS};
      end else if (opc == OPC_W'(OP_LD_DSP)) begin
         ctl = '{kind: K_LOAD, mode: M_DISP};
      end else if (opc == OPC_W'(OP_ST_DSP)) begin
         ctl = '{kind: K_STORE, mode: M_DISP};
      end else if (opc == OPC_W'(OP_EXT)) begin
         if (xop == XOP_W'(XOP_LD_IDX)) begin
            ctl = '{kind: K_LOAD, mode: M_INDEX};
         end else if (xop == XOP_W'(XOP_ST_IDX)) begin
            ctl = '{kind: K_STORE, mode: M_INDEX};
         end else if (xop == XOP_W'(XOP_PUSH)) begin
            ctl = '{kind: K_PUSH, mode: M_STACK};
         end else if (xop == XOP_W'(XOP_POP)) begin
            ctl = '{kind: K_POP, mode: M_STACK};
         end
      end
   end

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit SHARED_ADDER = 1'b1,
   parameter int STACK_STEP   = 1
) (
   input  amode_e          mode,
   input  logic            push_op,
   input  logic [XLEN-1:0] base_a,
   input  logic [XLEN-1:0] base_b,
   input  logic [XLEN-1:0] base_c,
   input  logic [XLEN-1:0] abs_addr,
   input  logic [XLEN-1:0] disp_val,
   output logic [XLEN-1:0] eff_addr,
   output logic [XLEN-1:0] ptr_next
);

   localparam logic [XLEN-1:0] STEP_UP   = XLEN'(STACK_STEP);
   localparam logic [XLEN-1:0] STEP_DOWN = -STEP_UP;

   generate
      if (STACK_STEP < 1) begin : g_bad_step
         $error("lsu_addr_gen: stack step must be at least one word");
      end

      if (SHARED_ADDER) begin : g_shared
         logic [XLEN-1:0] opx;
         logic [XLEN-1:0] opy;
         logic [XLEN-1:0] sum;

         always_comb begin
            case (mode)
               M_ABS: begin
                  opx = abs_addr;
                  opy = '0;
               end
               M_DISP: begin
                  opx = base_b;
                  opy = disp_val;
               end
               M_INDEX: begin
                  opx = base_b;
                  opy = base_c;
               end
               default: begin
                  opx = base_a;
                  opy = push_op ? STEP_UP : STEP_DOWN;
               end
            endcase
         end

         assign sum      = opx + opy;
         assign ptr_next = sum;
         assign eff_addr = ((mode == M_STACK) && !push_op) ? base_a : sum;
      end else begin : g_split
         logic [XLEN-1:0] sum_disp;
         logic [XLEN-1:0] sum_idx;
         logic [XLEN-1:0] ptr_inc;
         logic [XLEN-1:0] ptr_dec;

         assign sum_disp = base_b + disp_val;
         assign sum_idx  = base_b + base_c;
         assign ptr_inc  = base_a + STEP_UP;
         assign ptr_dec  = base_a - STEP_UP;
         assign ptr_next = push_op ? ptr_inc : ptr_dec;

         always_comb begin
            case (mode)
               M_ABS:   eff_addr = abs_addr;
               M_DISP:  eff_addr = sum_disp;
               M_INDEX: eff_addr = sum_idx;
               default: eff_addr = push_op ? ptr_inc : base_a;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/lsu_req_stage.sv
module lsu_req_stage
   import lsu_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_valid,
   input  acc_kind_e        kind,
   input  logic [IDX_W-1:0] fld1,
   input  logic [IDX_W-1:0] fld2,
   input  logic [XLEN-1:0]  eff_addr,
   input  logic [XLEN-1:0]  ptr_next,
   input  logic [XLEN-1:0]  base_a,
   input  logic [XLEN-1:0]  base_b,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             mem_rd_en,
   output logic             mem_wr_en,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   output logic             ptr_wr_en,
   output logic [IDX_W-1:0] ptr_wr_idx,
   output logic [XLEN-1:0]  ptr_wr_data,
   output logic             ld_wr_en,
   output logic [IDX_W-1:0] ld_wr_idx,
   output logic [XLEN-1:0]  ld_wr_data
);

   logic             go;
   logic             rd_nxt;
   logic             wr_nxt;
   logic             ptr_nxt;
   logic [XLEN-1:0]  wdata_nxt;
   logic [IDX_W-1:0] dest_nxt;
   logic [IDX_W-1:0] dest_q;

   assign go        = issue_valid && (kind != K_NONE);
   assign rd_nxt    = go && kind_reads(kind);
   assign wr_nxt    = go && kind_writes(kind);
   // a pop into its own pointer keeps only the loaded word
   assign ptr_nxt   = go && ((kind == K_PUSH) || ((kind == K_POP) && (fld1 != fld2)));
   assign wdata_nxt = (kind == K_PUSH) ? base_b : base_a;
   assign dest_nxt  = (kind == K_POP) ? fld2 : fld1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd_en   <= 1'b0;
         mem_wr_en   <= 1'b0;
         mem_addr    <= '0;
         mem_wdata   <= '0;
         ptr_wr_en   <= 1'b0;
         ptr_wr_idx  <= '0;
         ptr_wr_data <= '0;
         dest_q      <= '0;
      end else begin
         mem_rd_en   <= rd_nxt;
         mem_wr_en   <= wr_nxt;
         mem_addr    <= eff_addr;
         mem_wdata   <= wdata_nxt;
         ptr_wr_en   <= ptr_nxt;
         ptr_wr_idx  <= fld1;
         ptr_wr_data <= ptr_next;
         dest_q      <= dest_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_wr_en  <= 1'b0;
         ld_wr_idx <= '0;
      end else begin
         ld_wr_en  <= mem_rd_en;
         ld_wr_idx <= dest_q;
      end
   end

   assign ld_wr_data = mem_rdata;

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   p_wb_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wr_en |-> $past(mem_rd_en));

   p_ptr_has_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_en |-> (mem_rd_en || mem_wr_en));

   p_push_at_new_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && ptr_wr_en) |-> (mem_addr == ptr_wr_data));

   p_pop_steps_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && ptr_wr_en) |-> (ptr_wr_data == mem_addr - XLEN'(1)));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(issue_valid) |-> !(mem_rd_en || mem_wr_en || ptr_wr_en));

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
   import lsu_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int OPC_W        = 5,
   parameter int IDX_W        = 5,
   parameter int XOP_W        = 12,
   parameter bit SHARED_ADDER = 1'b1,
   parameter int STACK_STEP   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_valid,
   input  logic [XLEN-1:0]  issue_instr,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  opnd_b,
   input  logic [XLEN-1:0]  opnd_c,
   output logic             mem_rd_en,
   output logic             mem_wr_en,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             ptr_wr_en,
   output logic [IDX_W-1:0] ptr_wr_idx,
   output logic [XLEN-1:0]  ptr_wr_data,
   output logic             ld_wr_en,
   output logic [IDX_W-1:0] ld_wr_idx,
   output logic [XLEN-1:0]  ld_wr_data
);

   lsu_ctl_t         ctl;
   logic [IDX_W-1:0] fld1;
   logic [IDX_W-1:0] fld2;
   logic [XLEN-1:0]  abs_addr;
   logic [XLEN-1:0]  disp_val;
   logic [XLEN-1:0]  eff_addr;
   logic [XLEN-1:0]  ptr_next;

   lsu_decode #(
      .XLEN  (XLEN),
      .OPC_W (OPC_W),
      .IDX_W (IDX_W),
      .XOP_W (XOP_W)
   ) u_dec (
      .instr    (issue_instr),
      .ctl      (ctl),
      .fld1     (fld1),
      .fld2     (fld2),
      .abs_addr (abs_addr),
      .disp_val (disp_val)
   );

   lsu_addr_gen #(
      .XLEN         (XLEN),
      .SHARED_ADDER (SHARED_ADDER),
      .STACK_STEP   (STACK_STEP)
   ) u_agen (
      .mode     (ctl.mode),
      .push_op  (ctl.kind == K_PUSH),
      .base_a   (opnd_a),
      .base_b   (opnd_b),
      .base_c   (opnd_c),
      .abs_addr (abs_addr),
      .disp_val (disp_val),
      .eff_addr (eff_addr),
      .ptr_next (ptr_next)
   );

   lsu_req_stage #(
      .XLEN  (XLEN),
      .IDX_W (IDX_W)
   ) u_req (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .kind        (ctl.kind),
      .fld1        (fld1),
      .fld2        (fld2),
      .eff_addr    (eff_addr),
      .ptr_next    (ptr_next),
      .base_a      (opnd_a),
      .base_b      (opnd_b),
      .mem_rdata   (mem_rdata),
      .mem_rd_en   (mem_rd_en),
      .mem_wr_en   (mem_wr_en),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .ptr_wr_en   (ptr_wr_en),
      .ptr_wr_idx  (ptr_wr_idx),
      .ptr_wr_data (ptr_wr_data),
      .ld_wr_en    (ld_wr_en),
      .ld_wr_idx   (ld_wr_idx),
      .ld_wr_data  (ld_wr_data)
   );

endmodule

// File: tb/sim_lsu_addr_unit.sv
module sim_lsu_addr_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] KEY = 32'h5A5A_0F0F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [31:0] issue_instr = '0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [31:0] opnd_c = '0;
   logic        mem_rd_en;
   logic        mem_wr_en;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        ptr_wr_en;
   logic [4:0]  ptr_wr_idx;
   logic [31:0] ptr_wr_data;
   logic        ld_wr_en;
   logic [4:0]  ld_wr_idx;
   logic [31:0] ld_wr_data;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsu_addr_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .issue_instr (issue_instr),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .opnd_c      (opnd_c),
      .mem_rd_en   (mem_rd_en),
      .mem_wr_en   (mem_wr_en),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .ptr_wr_en   (ptr_wr_en),
      .ptr_wr_idx  (ptr_wr_idx),
      .ptr_wr_data (ptr_wr_data),
      .ld_wr_en    (ld_wr_en),
      .ld_wr_idx   (ld_wr_idx),
      .ld_wr_data  (ld_wr_data)
   );

   // memory model: read data is a function of the address, one cycle late
   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem_addr ^ KEY;
   end

   function automatic logic [31:0] f_l(logic [4:0] op, logic [4:0] r1, logic [21:0] ads);
      return {op, r1, ads};
   endfunction

   function automatic logic [31:0] f_d(logic [4:0] op, logic [4:0] r1, logic [4:0] r2,
                                       logic [16:0] d);
      return {op, r1, r2, d};
   endfunction

   function automatic logic [31:0] f_x(logic [4:0] r1, logic [4:0] r2, logic [4:0] r3,
                                       logic [11:0] xop);
      return {5'd31, r1, r2, r3, xop};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_quiet(input string tag);
      chk(tag, {28'd0, mem_rd_en, mem_wr_en, ptr_wr_en, ld_wr_en}, 32'd0);
   endtask

   // drive at a falling edge, return at the next falling edge (request visible)
   task automatic issue(input logic vld, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      issue_valid = vld;
      issue_instr = ins;
      opnd_a      = a;
      opnd_b      = b;
      opnd_c      = c;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk_quiet("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk_quiet("R1 after release");
   endtask

   task automatic t_absolute;
      issue(1'b1, f_l(5'd1, 5'd7, 22'h3FFFFF), 32'hFFFF_FFFF, 32'h0, 32'h0);
      chk("R2 abs load rd", {31'd0, mem_rd_en}, 32'd1);
      chk("R2 abs load zero-ext addr", mem_addr, 32'h003F_FFFF);
      @(negedge clk);
      chk("R5 abs load wb en", {31'd0, ld_wr_en}, 32'd1);
      chk("R5 abs load wb idx", {27'd0, ld_wr_idx}, 32'd7);
      chk("R5 abs load wb data", ld_wr_data, 32'h003F_FFFF ^ KEY);
      issue(1'b1, f_l(5'd3, 5'd9, 22'h000123), 32'hDEAD_BEEF, 32'h0, 32'h0);
      chk("R2 abs store wr", {30'd0, mem_wr_en, mem_rd_en}, 32'd2);
      chk("R2 abs store addr", mem_addr, 32'h0000_0123);
      chk("R2 abs store data", mem_wdata, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R2 abs store no wb", {31'd0, ld_wr_en}, 32'd0);
   endtask

   task automatic t_displacement;
      issue(1'b1, f_d(5'd2, 5'd3, 5'd4, 17'h1FFFF), 32'h0, 32'h0, 32'h0);
      chk("R3 disp load rd", {31'd0, mem_rd_en}, 32'd1);
      chk("R3 disp -1 on zero base", mem_addr, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R5 disp load wb idx", {27'd0, ld_wr_idx}, 32'd3);
      chk("R5 disp load wb data", ld_wr_data, 32'hFFFF_FFFF ^ KEY);
      issue(1'b1, f_d(5'd4, 5'd8, 5'd4, 17'h0FFFF), 32'h1234_5678, 32'h0000_0100, 32'h0);
      chk("R3 disp store wr", {31'd0, mem_wr_en}, 32'd1);
      chk("R3 disp max positive", mem_addr, 32'h0001_00FF);
      chk("R3 disp store data", mem_wdata, 32'h1234_5678);
      @(negedge clk);
   endtask

   task automatic t_index;
      issue(1'b1, f_x(5'd10, 5'd11, 5'd12, 12'd17), 32'h0, 32'hFFFF_FFF0, 32'h0000_0020);
      chk("R4 index load rd", {31'd0, mem_rd_en}, 32'd1);
      chk("R4 index wrap", mem_addr, 32'h0000_0010);
      @(negedge clk);
      chk("R5 index load wb idx", {27'd0, ld_wr_idx}, 32'd10);
      issue(1'b1, f_x(5'd13, 5'd1, 5'd2, 12'd18), 32'h0000_000A, 32'd5, 32'd6);
      chk("R4 index store wr", {31'd0, mem_wr_en}, 32'd1);
      chk("R4 index store addr", mem_addr, 32'd11);
      chk("R4 index store data", mem_wdata, 32'h0000_000A);
      @(negedge clk);
   endtask

   task automatic t_push;
      issue(1'b1, f_x(5'd28, 5'd3, 5'd0, 12'd21), 32'd1999, 32'h0000_CAFE, 32'h0);
      chk("R6 push wr", {30'd0, mem_wr_en, mem_rd_en}, 32'd2);
      chk("R6 push addr is new ptr", mem_addr, 32'd2000);
      chk("R6 push data", mem_wdata, 32'h0000_CAFE);
      chk("R6 push ptr en", {31'd0, ptr_wr_en}, 32'd1);
      chk("R6 push ptr idx", {27'd0, ptr_wr_idx}, 32'd28);
      chk("R6 push ptr value", ptr_wr_data, 32'd2000);
      @(negedge clk);
      chk("R6 push no wb", {31'd0, ld_wr_en}, 32'd0);
      issue(1'b1, f_x(5'd2, 5'd3, 5'd0, 12'd21), 32'hFFFF_FFFF, 32'h1, 32'h0);
      chk("R6 push wrap addr", mem_addr, 32'h0);
      chk("R6 push wrap ptr", ptr_wr_data, 32'h0);
      @(negedge clk);
   endtask

   task automatic t_pop;
      issue(1'b1, f_x(5'd28, 5'd5, 5'd0, 12'd22), 32'd2000, 32'h0, 32'h0);
      chk("R7 pop rd", {30'd0, mem_wr_en, mem_rd_en}, 32'd1);
      chk("R7 pop addr is old ptr", mem_addr, 32'd2000);
      chk("R7 pop ptr en", {31'd0, ptr_wr_en}, 32'd1);
      chk("R7 pop ptr idx", {27'd0, ptr_wr_idx}, 32'd28);
      chk("R7 pop ptr value", ptr_wr_data, 32'd1999);
      @(negedge clk);
      chk("R7 pop wb en", {31'd0, ld_wr_en}, 32'd1);
      chk("R7 pop wb idx", {27'd0, ld_wr_idx}, 32'd5);
      chk("R7 pop wb data", ld_wr_data, 32'd2000 ^ KEY);
      issue(1'b1, f_x(5'd4, 5'd5, 5'd0, 12'd22), 32'h0, 32'h0, 32'h0);
      chk("R7 pop wrap ptr", ptr_wr_data, 32'hFFFF_FFFF);
      @(negedge clk);
   endtask

   task automatic t_pop_same;
      issue(1'b1, f_x(5'd6, 5'd6, 5'd0, 12'd22), 32'd50, 32'd50, 32'h0);
      chk("R8 pop same rd", {31'd0, mem_rd_en}, 32'd1);
      chk("R8 pop same addr", mem_addr, 32'd50);
      chk("R8 pop same no ptr write", {31'd0, ptr_wr_en}, 32'd0);
      @(negedge clk);
      chk("R8 pop same wb en", {31'd0, ld_wr_en}, 32'd1);
      chk("R8 pop same wb idx", {27'd0, ld_wr_idx}, 32'd6);
      chk("R8 pop same wb data", ld_wr_data, 32'd50 ^ KEY);
      chk("R8 pop same ptr still quiet", {31'd0, ptr_wr_en}, 32'd0);
   endtask

   task automatic t_ignored;
      issue(1'b1, f_d(5'd10, 5'd1, 5'd2, 17'd5), 32'h1, 32'h2, 32'h3);
      chk_quiet("R9 arithmetic opcode");
      issue(1'b1, f_x(5'd1, 5'd2, 5'd3, 12'd0), 32'h1, 32'h2, 32'h3);
      chk_quiet("R9 extended add");
      issue(1'b1, f_x(5'd1, 5'd2, 5'd3, 12'd23), 32'h1, 32'h2, 32'h3);
      chk_quiet("R9 extended undefined");
      issue(1'b1, f_l(5'd0, 5'd1, 22'h10), 32'h1, 32'h2, 32'h3);
      chk_quiet("R9 opcode zero");
      issue(1'b0, f_l(5'd1, 5'd1, 22'h10), 32'h1, 32'h2, 32'h3);
      chk_quiet("R9 valid low");
      @(negedge clk);
      chk_quiet("R9 valid low no wb");
   endtask

   task automatic t_back_to_back;
      issue(1'b1, f_l(5'd1, 5'd2, 22'h40), 32'h0, 32'h0, 32'h0);
      chk("R11 b2b load rd", {30'd0, mem_wr_en, mem_rd_en}, 32'd1);
      chk("R11 b2b load addr", mem_addr, 32'h40);
      issue(1'b1, f_d(5'd4, 5'd3, 5'd4, 17'd2), 32'h0000_0333, 32'h10, 32'h0);
      chk("R10 b2b store only wr", {30'd0, mem_wr_en, mem_rd_en}, 32'd2);
      chk("R11 b2b store addr", mem_addr, 32'h12);
      chk("R11 b2b overlapped wb en", {31'd0, ld_wr_en}, 32'd1);
      chk("R11 b2b overlapped wb idx", {27'd0, ld_wr_idx}, 32'd2);
      chk("R11 b2b overlapped wb data", ld_wr_data, 32'h40 ^ KEY);
      issue(1'b1, f_x(5'd5, 5'd6, 5'd0, 12'd21), 32'd7, 32'h77, 32'h0);
      chk("R10 b2b push only wr", {30'd0, mem_wr_en, mem_rd_en}, 32'd2);
      chk("R11 b2b push addr", mem_addr, 32'd8);
      chk("R11 b2b push ptr", ptr_wr_data, 32'd8);
      chk("R11 b2b store no wb", {31'd0, ld_wr_en}, 32'd0);
      @(negedge clk);
      chk_quiet("R11 b2b drained");
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      t_reset();
      t_absolute();
      t_displacement();
      t_index();
      t_push();
      t_pop();
      t_pop_same();
      t_ignored();
      t_back_to_back();
      repeat (2) @(negedge clk);
      report();
   end

endmodule